// File: doc/BRIEF.md
# Per-Input Edge/Level Interrupt Request Detector

This block sits in front of an interrupt priority unit. It takes eight raw request lines, brings each into the clock domain through a synchroniser, and turns each one into a pending-request bit. A separate 8-bit trigger-select register sets how each line is read. A cleared bit means a request is a rising edge, which the block latches. A set bit means the request is the high level itself, with no latch. The trigger-mode bit of the first initialization command word is still accepted at the ports, but it has no effect on any line.

The priority unit picks the line to serve and reports it to the block with a first-acknowledge strobe and the line's index. The block then checks that this line is still pending. If it is, the block asks for that line's in-service bit to be set, and an edge latch is consumed at that point. If the line has already dropped, the acknowledge is spurious: the block names line 7 as the vector source and does not set any in-service bit. A level line that is still high when the routine ends stays pending, so it raises a new interrupt.

Top module: `irq_trigger_detect`

## Requirements
- R1: After reset, `mode_o` is 0 (every line in edge mode), and `pend_o`, `ack_vld_o`, `isr_set_o`, `spur_o` and `ack_src_o` are all 0.
- R2: For a line whose trigger bit is 0 (edge), a 0-to-1 change on `irq_i` sets its `pend_o` bit at the third rising clock edge after the change. The bit then holds even if the input falls. An input that stays high after the latch is consumed never sets the bit again.
- R3: For a line whose trigger bit is 1 (level), `pend_o` is `irq_i` delayed by two rising clock edges. No edge is needed.
- R4: A write with `mode_we_i` loads `mode_wdata_i` into the trigger register at that edge, and bit i selects line i. The write also clears the edge latch of every line it sets to level.
- R5: A pulse on `icw1_we_i` has no effect on `mode_o` or on the detection of any line, whatever the value of `icw1_level_i`.
- R6: When `ack1_i` is high with `ack_sel_i` = k and `pend_o[k]` is 1, the next edge gives `ack_vld_o`=1, `isr_set_o` = 1<<k, `ack_src_o`=k and `spur_o`=0, each for one cycle.
- R7: A valid acknowledge of an edge-mode line clears its `pend_o` bit at the same edge, unless a new rising edge is detected on that line in the same cycle.
- R8: A valid acknowledge of a level-mode line leaves its `pend_o` bit at 1 for as long as the input stays high, so the request comes back after the routine ends.
- R9: When `ack1_i` is high with `ack_sel_i` = k and `pend_o[k]` is 0 (for example, a level line that dropped before the acknowledge), the next edge gives `ack_vld_o`=1, `spur_o`=1, `ack_src_o`=7 and `isr_set_o`=0. This holds for k=7 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Raw request lines |
| mode_we_i | input | 1 | Write strobe for the trigger-select register |
| mode_wdata_i | input | 8 | Trigger-select data, 1 = level, 0 = edge |
| icw1_we_i | input | 1 | Strobe for the first initialization word (its trigger bit is ignored) |
| icw1_level_i | input | 1 | Legacy global trigger bit, has no effect |
| ack1_i | input | 1 | First-acknowledge strobe from the arbiter |
| ack_sel_i | input | 3 | Index of the line being acknowledged |
| mode_o | output | 8 | Current trigger-select register |
| pend_o | output | 8 | Pending-request bits |
| ack_vld_o | output | 1 | Acknowledge result is valid (one cycle) |
| isr_set_o | output | 8 | One-hot request to set an in-service bit |
| spur_o | output | 1 | The acknowledge was spurious |
| ack_src_o | output | 3 | Vector source index (7 when spurious) |

## Verification
Each result has a fixed latency, and the bench samples it exactly then. A level line's pending bit is due two edges after its input changes. An edge line's bit is due three edges after the change. Mode writes and acknowledge results appear one edge after their strobe. Every input is driven on the falling clock edge, and the bench counts rising edges from that point. It checks pending bits after one, two and three edges, so it catches both an early and a late result. Acknowledge outputs and the clearing of latches are read just after the edge on which the strobe is taken.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  localparam int unsigned DEF_N_IRQ       = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
  import irq_trig_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  trig_mode_e mode_i,
  input  logic       mode_we_i,
  input  trig_mode_e mode_next_i,
  input  logic       sync_i,
  input  logic       clr_i,
  output logic       pend_o
);

  logic prev_q;
  logic edge_q;
  logic rise;
  logic drop_latch;

  assign rise       = (mode_i == TRIG_EDGE) && sync_i && !prev_q;
  assign drop_latch = mode_we_i && (mode_next_i == TRIG_LEVEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (drop_latch) edge_q <= 1'b0;
      else            edge_q <= (edge_q && !clr_i) || rise;
    end
  end

  assign pend_o = (mode_i == TRIG_LEVEL) ? sync_i : edge_q;

  // a held-high input cannot re-arm a consumed latch
  assert_no_retrigger_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_EDGE && prev_q && !edge_q) |=> !edge_q);

  assert_latch_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_EDGE && edge_q && !clr_i && !mode_we_i) |=> edge_q);

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise) |=> !edge_q);

endmodule

// File: rtl/irq_ack_check.sv
module irq_ack_check
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_IRQ = DEF_N_IRQ,
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int unsigned SPUR_IDX = N_IRQ - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack1_i,
  input  logic [IDX_W-1:0] ack_sel_i,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] mode_i,
  output logic [N_IRQ-1:0] clr_o,
  output logic             ack_vld_o,
  output logic [N_IRQ-1:0] isr_set_o,
  output logic             spur_o,
  output logic [IDX_W-1:0] ack_src_o
);

  logic             hit;
  logic             take;
  logic [N_IRQ-1:0] sel_oh;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_sel
    assign sel_oh[i] = (ack_sel_i == IDX_W'(i));
    assign clr_o[i]  = take && sel_oh[i] && (mode_i[i] == TRIG_EDGE);
  end

  assign hit  = |(sel_oh & pend_i);
  assign take = ack1_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o <= 1'b0;
      isr_set_o <= '0;
      spur_o    <= 1'b0;
      ack_src_o <= '0;
    end else begin
      ack_vld_o <= ack1_i;
      isr_set_o <= take ? sel_oh : '0;
      spur_o    <= ack1_i && !hit;
      if (ack1_i) ack_src_o <= hit ? ack_sel_i : IDX_W'(SPUR_IDX);
      else        ack_src_o <= '0;
    end
  end

  assert_isr_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_set_o));

endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_IRQ       = DEF_N_IRQ,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int unsigned SPUR_IDX = N_IRQ - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             mode_we_i,
  input  logic [N_IRQ-1:0] mode_wdata_i,
  input  logic             icw1_we_i,
  input  logic             icw1_level_i,
  input  logic             ack1_i,
  input  logic [IDX_W-1:0] ack_sel_i,
  output logic [N_IRQ-1:0] mode_o,
  output logic [N_IRQ-1:0] pend_o,
  output logic             ack_vld_o,
  output logic [N_IRQ-1:0] isr_set_o,
  output logic             spur_o,
  output logic [IDX_W-1:0] ack_src_o
);

  logic [N_IRQ-1:0] mode_q;
  logic [N_IRQ-1:0] irq_sync;
  logic [N_IRQ-1:0] clr;
  logic             unused_icw1;

  // legacy global trigger bit is accepted and dropped
  assign unused_icw1 = icw1_we_i ^ icw1_level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end

  assign mode_o = mode_q;

  irq_sync #(
    .WIDTH  (N_IRQ),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (irq_sync)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_cell
    irq_trig_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (trig_mode_e'(mode_q[i])),
      .mode_we_i   (mode_we_i),
      .mode_next_i (trig_mode_e'(mode_wdata_i[i])),
      .sync_i      (irq_sync[i]),
      .clr_i       (clr[i]),
      .pend_o      (pend_o[i])
    );
  end

  irq_ack_check #(
    .N_IRQ (N_IRQ)
  ) u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack1_i    (ack1_i),
    .ack_sel_i (ack_sel_i),
    .pend_i    (pend_o),
    .mode_i    (mode_q),
    .clr_o     (clr),
    .ack_vld_o (ack_vld_o),
    .isr_set_o (isr_set_o),
    .spur_o    (spur_o),
    .ack_src_o (ack_src_o)
  );

  assert_icw1_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icw1_we_i && !mode_we_i) |=> $stable(mode_o));

  assert_valid_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack1_i && pend_o[ack_sel_i]) |=>
      (ack_vld_o && !spur_o && isr_set_o == (N_IRQ'(1) << $past(ack_sel_i))
       && ack_src_o == $past(ack_sel_i)));

  assert_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack1_i && !pend_o[ack_sel_i]) |=>
      (ack_vld_o && spur_o && isr_set_o == '0 && ack_src_o == IDX_W'(SPUR_IDX)));

endmodule

// File: tb/irq_trigger_detect_tb.sv
module irq_trigger_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       icw1_we = 1'b0;
  logic       icw1_level = 1'b0;
  logic       ack1 = 1'b0;
  logic [2:0] ack_sel = '0;
  logic [7:0] mode_o, pend_o, isr_set_o;
  logic       ack_vld_o, spur_o;
  logic [2:0] ack_src_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_trigger_detect u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .irq_i        (irq),
    .mode_we_i    (mode_we),
    .mode_wdata_i (mode_wdata),
    .icw1_we_i    (icw1_we),
    .icw1_level_i (icw1_level),
    .ack1_i       (ack1),
    .ack_sel_i    (ack_sel),
    .mode_o       (mode_o),
    .pend_o       (pend_o),
    .ack_vld_o    (ack_vld_o),
    .isr_set_o    (isr_set_o),
    .spur_o       (spur_o),
    .ack_src_o    (ack_src_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_we = 1'b1; mode_wdata = v;
    step(1);
    mode_we = 1'b0;
  endtask

  task automatic do_ack(input logic [2:0] sel);
    ack1 = 1'b1; ack_sel = sel;
    step(1);
    ack1 = 1'b0;
  endtask

  task automatic line_test(input logic [7:0] pat, input int i);
    logic       lvl;
    logic [7:0] oh;
    lvl = pat[i];
    oh  = 8'(1) << i;
    irq[i] = 1'b1;
    step(1); chk("R2/R3 one edge", pend_o, 0);
    step(1); chk("R2/R3 two edges", pend_o, lvl ? oh : 8'h00);
    step(1); chk("R2/R3 three edges", pend_o, oh);
    step(2); chk("R2/R3 held", pend_o, oh);
    do_ack(3'(i));
    chk("R6 vld", {ack_vld_o, spur_o}, 2'b10);
    chk("R6 isr", isr_set_o, oh);
    chk("R6 src", ack_src_o, i);
    chk("R7/R8 after ack", pend_o, lvl ? oh : 8'h00);
    step(1); chk("R6 pulse", ack_vld_o, 0);
    step(3); chk("R2 no retrigger / R8 level stays", pend_o, lvl ? oh : 8'h00);
    irq[i] = 1'b0;
    step(3); chk("R2/R3 released", pend_o, 0);
    do_ack(3'(i));
    chk("R9 spur", {ack_vld_o, spur_o}, 2'b11);
    chk("R9 src", ack_src_o, 7);
    chk("R9 isr", isr_set_o, 0);
    // early drop before the acknowledge
    irq[i] = 1'b1; step(3);
    irq[i] = 1'b0; step(3);
    chk("R2/R3 early drop", pend_o, lvl ? 8'h00 : oh);
    do_ack(3'(i));
    chk("R6/R9 early drop spur", spur_o, lvl);
    chk("R6/R9 early drop isr", isr_set_o, lvl ? 8'h00 : oh);
    chk("R9 early drop src", ack_src_o, lvl ? 3'd7 : 3'(i));
    chk("R7 consumed", pend_o, 0);
  endtask

  initial begin
    step(2);
    chk("R1 mode", mode_o, 0);
    chk("R1 pend", pend_o, 0);
    chk("R1 ack", {ack_vld_o, spur_o, isr_set_o, ack_src_o}, 0);
    rst_n = 1'b1;
    step(1);

    // R4: a level write discards a held edge latch
    irq[0] = 1'b1; step(3);
    irq[0] = 1'b0; step(3);
    chk("R4 latch held", pend_o, 8'h01);
    write_mode(8'h01);
    chk("R4 mode load", mode_o, 8'h01);
    chk("R4 latch discarded", pend_o, 0);
    write_mode(8'h00);
    chk("R4 back to edge", pend_o, 0);

    foreach (pat_list[p]) begin
      write_mode(pat_list[p]);
      chk("R4 mode", mode_o, pat_list[p]);
      icw1_we = 1'b1; icw1_level = ~pat_list[p][0];
      step(1);
      icw1_we = 1'b0;
      chk("R5 icw1 ignored", mode_o, pat_list[p]);
      for (int i = 0; i < 8; i++) line_test(pat_list[p], i);
    end

    // R5: legacy bit set while in edge mode, held input still latches once
    write_mode(8'h00);
    icw1_we = 1'b1; icw1_level = 1'b1; step(1); icw1_we = 1'b0;
    irq = 8'hFF; step(3);
    chk("R5 edge kept", pend_o, 8'hFF);
    irq = 8'h00; step(3);
    chk("R5 edge latched", pend_o, 8'hFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  logic [7:0] pat_list [3] = '{8'h00, 8'hFF, 8'h5A};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule